// File: doc/BRIEF.md
# Interrupt Status Summary Controller

This block holds the event status word and the interrupt enable word of a network controller. It drives one level-sensitive interrupt request. The transmit, receive and link logic pulse event inputs, one per cause bit. Each pulse sets a sticky cause bit. Software reads the status word, clears causes by writing ones to them, and programs the enable word.

Two summary bits are derived from the causes that are both set and enabled. The normal summary collects the routine completion causes. The abnormal summary collects the error and link causes. The interrupt request is raised only through an enabled summary bit. The status word also carries two 3-bit process-state fields, one for receive and one for transmit. Neighbouring logic loads these fields through dedicated inputs. A software-reset command returns both words to their reset values.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, `status_o` is 0xF0000000, `enable_o` is 0xF3FE0000 and `irq_o` is 0.
- R2: A 1 on `evt_set[i]` sets cause bit i, and the bit stays set until it is cleared. The cause bit positions are:
  - Normal group: tx complete 0, tx unavailable 2, rx complete 6, timer 11, early rx 14.
  - Abnormal group: tx stopped 1, jabber 3, link pass 4, underflow 5, rx unavailable 7, rx stopped 8, rx watchdog 9, early tx 10, link fail 12, bus error 13, port event 26, link changed 27.
- R3: When `stat_wr` is 1, every cause bit whose `stat_data` bit is 1 is cleared. Cause bits whose `stat_data` bit is 0 keep their value.
- R4: If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 16 (normal summary) is 1 exactly when some normal-group cause is set and its enable bit is 1.
- R6: Status bit 15 (abnormal summary) is 1 exactly when some abnormal-group cause is set and its enable bit is 1.
- R7: `irq_o` is registered. One clock after the status or enable word changes, it equals (bit 16 of status AND bit 16 of enable) OR (bit 15 of status AND bit 15 of enable).
- R8: `rx_state_wr` loads `rx_state_in` into status bits 19:17, and `tx_state_wr` loads `tx_state_in` into bits 22:20. Status writes and event inputs leave these fields unchanged.
- R9: Writing 1 to a summary bit has no lasting effect. The summary bit stays set while an enabled cause in its group remains set.
- R10: Events on bits that are not causes are ignored, and status bits 31:28 always read as 1.
- R11: `soft_rst` restores both words to their reset values. `irq_o` is 0 after the same clock edge.
- R12: `en_wr` loads `en_data` into the enable word exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset command |
| evt_set | input | 32 | Per-bit event pulses |
| stat_wr | input | 1 | Write-one-to-clear strobe for the status word |
| stat_data | input | 32 | Clear mask |
| en_wr | input | 1 | Enable word write strobe |
| en_data | input | 32 | New enable word |
| rx_state_wr | input | 1 | Load strobe for the receive state field |
| rx_state_in | input | 3 | Receive state value |
| tx_state_wr | input | 1 | Load strobe for the transmit state field |
| tx_state_in | input | 3 | Transmit state value |
| status_o | output | 32 | Status word with summaries and state fields |
| enable_o | output | 32 | Enable word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a summary bit that is set while the interrupt request stays low. This happens when a cause is enabled but the matching summary enable is not. The vector walk reaches it by dropping bit 15 of the enable word while an enabled abnormal cause is still pending. It then writes a 1 to the summary bit to show that the clear does not stick. The collision of an event and a clear on the same bit is forced in one vector. The process-state fields are written and then hit with an all-ones clear and with events on their bit positions.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int          W        = 32,
  parameter logic [31:0] STAT_RST = 32'hF000_0000,
  parameter logic [31:0] EN_RST   = 32'hF3FE_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] evt_set,
  input  logic         stat_wr,
  input  logic [W-1:0] stat_data,
  input  logic         en_wr,
  input  logic [W-1:0] en_data,
  input  logic         rx_state_wr,
  input  logic [2:0]   rx_state_in,
  input  logic         tx_state_wr,
  input  logic [2:0]   tx_state_in,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);
  localparam int          AIS_B     = 15;
  localparam int          NIS_B     = 16;
  localparam int          RX_LO     = 17;
  localparam int          TX_LO     = 20;
  localparam logic [W-1:0] NORM_GRP = W'(32'h0000_4845);
  localparam logic [W-1:0] ABN_GRP  = W'(32'h0C00_37BA);
  localparam logic [W-1:0] CAUSES   = NORM_GRP | ABN_GRP;
  localparam logic [W-1:0] FIXED    = W'(STAT_RST) & ~CAUSES;

  logic [W-1:0] cause_q, en_q;
  logic [2:0]   rx_q, tx_q;
  logic         irq_q;

  wire [W-1:0] clr_vec = stat_wr ? stat_data : '0;
  wire [W-1:0] live    = cause_q & en_q;
  wire         nis     = |(live & NORM_GRP);
  wire         ais     = |(live & ABN_GRP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      en_q    <= W'(EN_RST);
      rx_q    <= '0;
      tx_q    <= '0;
      irq_q   <= 1'b0;
    end else if (soft_rst) begin
      cause_q <= '0;
      en_q    <= W'(EN_RST);
      rx_q    <= '0;
      tx_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= ((cause_q & ~clr_vec) | evt_set) & CAUSES;
      if (en_wr)       en_q <= en_data;
      if (rx_state_wr) rx_q <= rx_state_in;
      if (tx_state_wr) tx_q <= tx_state_in;
      irq_q <= (nis & en_q[NIS_B]) | (ais & en_q[AIS_B]);
    end
  end

  always_comb begin
    status_o              = FIXED | cause_q;
    status_o[AIS_B]       = ais;
    status_o[NIS_B]       = nis;
    status_o[RX_LO +: 3]  = rx_q;
    status_o[TX_LO +: 3]  = tx_q;
  end

  assign enable_o = en_q;
  assign irq_o    = irq_q;

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((($past(cause_q) & ~$past(clr_vec)) & ~cause_q) == '0)); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((($past(evt_set) & CAUSES) & ~cause_q) == '0)); // R4
  AST_RX_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !rx_state_wr) |=> $stable(rx_q)); // R8
  AST_TX_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !tx_state_wr) |=> $stable(tx_q)); // R8
  AST_IRQ_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(nis | ais)); // R7
  AST_SOFT_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq_o && cause_q == '0)); // R11
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] evt_set = '0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_data = '0;
  logic        en_wr = 1'b0;
  logic [31:0] en_data = '0;
  logic        rx_state_wr = 1'b0;
  logic [2:0]  rx_state_in = '0;
  logic        tx_state_wr = 1'b0;
  logic [2:0]  tx_state_in = '0;
  logic [31:0] status_o, enable_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .evt_set(evt_set), .stat_wr(stat_wr), .stat_data(stat_data),
    .en_wr(en_wr), .en_data(en_data),
    .rx_state_wr(rx_state_wr), .rx_state_in(rx_state_in),
    .tx_state_wr(tx_state_wr), .tx_state_in(tx_state_in),
    .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
  );

  // {evt, clr, enable, expected status, expected irq}
  localparam logic [128:0] VEC [8] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0001_0001, 32'hF001_0001, 1'b1}, // R2 R5
    {32'h0000_0080, 32'h0000_0000, 32'h0001_0001, 32'hF001_0081, 1'b1}, // R6 not enabled
    {32'h0000_0000, 32'h0000_0001, 32'h0000_8080, 32'hF000_8080, 1'b1}, // R3 R6
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0080, 32'hF000_8080, 1'b0}, // R7 summary gated
    {32'h0800_0000, 32'h0000_8000, 32'h0001_0080, 32'hF800_8080, 1'b0}, // R9
    {32'h0000_4000, 32'h0000_0080, 32'h0001_4000, 32'hF801_4000, 1'b1}, // R3 R5
    {32'h0000_0004, 32'h0000_0004, 32'h0001_0004, 32'hF801_4004, 1'b1}, // R4
    {32'hF0E0_0000, 32'h0FFF_FFFF, 32'hFFFF_FFFF, 32'hF000_0000, 1'b0}  // R10 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_set = '0; stat_wr = 1'b0; stat_data = '0; en_wr = 1'b0;
    rx_state_wr = 1'b0; tx_state_wr = 1'b0; soft_rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", status_o, 32'hF000_0000);
    check("R1 enable", enable_o, 32'hF3FE_0000);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      evt_set = VEC[i][128:97];
      stat_wr = 1'b1; stat_data = VEC[i][96:65];
      en_wr = 1'b1; en_data = VEC[i][64:33];
      @(negedge clk);
      idle();
      check($sformatf("R2-vector%0d status", i), status_o, VEC[i][32:1]);
      check($sformatf("R12 vector%0d enable", i), enable_o, VEC[i][64:33]);
      @(negedge clk);
      check($sformatf("R7 vector%0d irq", i), {31'b0, irq_o}, {31'b0, VEC[i][0]});
    end

    // R7: irq latency of exactly one clock after status change
    en_wr = 1'b1; en_data = 32'h0001_0001;
    @(negedge clk); idle();
    evt_set = 32'h0000_0001;
    @(negedge clk); idle();
    check("R7 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 irq one clock later", {31'b0, irq_o}, 32'h1);

    // R11: software reset
    soft_rst = 1'b1;
    @(negedge clk); idle();
    check("R11 status", status_o, 32'hF000_0000);
    check("R11 enable", enable_o, 32'hF3FE_0000);
    check("R11 irq", {31'b0, irq_o}, 32'h0);

    // R8: state fields
    rx_state_wr = 1'b1; rx_state_in = 3'd5;
    tx_state_wr = 1'b1; tx_state_in = 3'd3;
    @(negedge clk); idle();
    check("R8 state load", status_o, 32'hF03A_0000);
    stat_wr = 1'b1; stat_data = 32'hFFFF_FFFF;
    @(negedge clk); idle();
    check("R8 clear ignores state", status_o, 32'hF03A_0000);
    evt_set = 32'h007E_0000;
    @(negedge clk); idle();
    check("R8 events ignore state", status_o, 32'hF03A_0000);
    check("R10 no irq from state bits", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule